// File: doc/BRIEF.md
# Strided Line Copy Engine

The block copies raw 128-bit beats from a source buffer to a destination buffer without changing the data. Each side has its own line length and its own gap. After a side has moved one line, its address jumps over the gap before the next line starts. This lets software copy a sub-rectangle between two surfaces whose row pitches differ. The gap bytes are never counted as part of the transfer.

Software programs the engine through a small word-indexed register file, then sets the start bit. The engine issues read requests on a ready/valid port and sends the returned beats through a small FIFO. It drains that FIFO on a ready/valid write port. A read is only issued when a FIFO slot is free for its response. When the last write is accepted, the engine sets a done flag and pulses an interrupt.

Parameter sets that would make the transfer ill-defined are refused at launch. A refused start finishes at once with an error flag and makes no memory access.

Top module: `scopy_engine`

## Requirements
- R1: Registers are selected by `reg_addr`: 0 source base, 1 destination base, 2 byte count, 3 source shape, 4 destination shape, 5 flags, 6 control. Registers 0 to 5 read back exactly what was written. A base register holds the byte address shifted right by 3. A shape register holds the line width in bits 15:0 and the gap in bits 31:16, both in 16-byte beats.
- R2: Writing control with bit 0 set while idle launches a transfer. The control register reads busy on bit 0, done on bit 8 and error on bit 9. At completion, busy clears and done sets.
- R3: When flags bit 2 is clear, both sides step by 16 bytes every beat and the shape registers are ignored. All flag bits other than bit 2 have no effect.
- R4: When flags bit 2 is set, each side independently adds (gap+1)*16 bytes after the last beat of every line of `width` beats, and adds 16 bytes otherwise. A gap of 0 gives contiguous addresses.
- R5: A transfer moves ceil(count/16) beats on each side. Gap bytes do not add to this number. A final partial line is moved and the engine then stops.
- R6: Write beat k carries the data returned for read beat k, in the same order.
- R7: A launch is refused if, in contiguous mode, the count is below 16. It is also refused if, in gapped mode, the count is below 192 or either line width is 0. A refused launch sets done and error on the start edge, pulses the interrupt and issues no read or write.
- R8: `irq` is high for exactly one cycle. It rises on the same edge that sets done.
- R9: A start written while busy is ignored. The running transfer moves exactly its own beat count and completes once.
- R10: A read or write request that is stalled keeps its valid high and its address and data stable. Requests issued but not yet written out never exceed the FIFO depth.
- R11: After reset, every register reads 0, and `rd_valid`, `wr_valid` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 32 | Read byte address |
| rd_rvalid | input | 1 | Read response valid (no back-pressure) |
| rd_rdata | input | 128 | Read response data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 128 | Write data |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the memory side returns exactly one response per accepted read, in request order, and only after that read was accepted. They also assume the configuration registers are not rewritten while a transfer is running. The bench keeps within these limits: its read responder answers only from a queue of accepted requests, it throttles responses and ready signals at random, and it programs registers only while the engine is idle. The only register write it makes during a run is the deliberate restart attempt.

// File: rtl/scopy_pkg.sv
// Package: shared register indices for the strided copy engine.
// Assumes a word-indexed register file of at most eight entries.
package scopy_pkg;
    typedef enum logic [2:0] {
        REG_SRC_BASE  = 3'd0,
        REG_DST_BASE  = 3'd1,
        REG_COUNT     = 3'd2,
        REG_SRC_SHAPE = 3'd3,
        REG_DST_SHAPE = 3'd4,
        REG_FLAGS     = 3'd5,
        REG_CTRL      = 3'd6
    } scopy_reg_e;

    localparam int CTRL_BUSY_BIT = 0;
    localparam int CTRL_DONE_BIT = 8;
    localparam int CTRL_ERR_BIT  = 9;
    localparam int FLAG_GAP_BIT  = 2;
    localparam int BEAT_BYTES    = 16;
    localparam int MIN_FLAT      = 16;
    localparam int MIN_GAPPED    = 192;
endpackage

// File: rtl/scopy_agen.sv
// Module: per-side address walker. It latches the base address, line width,
// gap and mode on load, then advances one beat on each step.
// Assumes the width is nonzero whenever gapped mode is loaded.
module scopy_agen #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] width,
    input  logic [LW-1:0] gap,
    input  logic          gapped,
    input  logic          step,
    output logic [AW-1:0] addr
);
    logic [LW-1:0] col;
    logic [LW-1:0] width_q;
    logic [LW-1:0] gap_q;
    logic          gapped_q;
    logic          line_end;

    // Last beat of a line, only meaningful in gapped mode.
    assign line_end = gapped_q && (col == width_q - LW'(1));

    // Latch the line shape at load time and walk the address per beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr     <= '0;
            col      <= '0;
            width_q  <= '0;
            gap_q    <= '0;
            gapped_q <= 1'b0;
        end else if (load) begin
            addr     <= base;
            col      <= '0;
            width_q  <= width;
            gap_q    <= gap;
            gapped_q <= gapped;
        end else if (step) begin
            if (line_end) begin
                col  <= '0;
                addr <= addr + ((AW'(gap_q) + AW'(1)) << 4);
            end else begin
                col  <= col + LW'(1);
                addr <= addr + AW'(16);
            end
        end
    end
endmodule

// File: rtl/scopy_fifo.sv
// Module: small synchronous FIFO that holds beats between read and write.
// Assumes DEPTH is a power of two and the caller never pushes when full.
module scopy_fifo #(
    parameter int DW    = 128,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    assign dout  = mem[rp];
    assign empty = (cnt == '0);

    // Storage write, no reset needed.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + PW'(1);
            if (pop)  rp <= rp + PW'(1);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/scopy_engine.sv
// Module: strided line copy engine top. It holds the register file, checks
// the parameters at launch, issues credited reads and drains the FIFO to writes.
// Assumes read responses arrive in order, one per accepted request.
module scopy_engine
    import scopy_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 128,
    parameter int FIFO_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_rvalid,
    input  logic [DW-1:0] rd_rdata,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          irq
);
    localparam int OCC_W = $clog2(FIFO_DEPTH + 1);
    localparam int LW    = 16;

    logic [31:0] r_src, r_dst, r_count, r_sshape, r_dshape, r_flags;
    logic        busy, done, err;
    logic [31:0] beats, rd_left, wr_left;
    logic [OCC_W-1:0] occ;
    logic        gapped, legal, start_req, launch;
    logic        rd_fire, wr_fire, fifo_empty;

    assign gapped    = r_flags[FLAG_GAP_BIT];
    assign beats     = {4'b0, r_count[31:4]} + {31'b0, |r_count[3:0]};
    assign legal     = gapped ? ((r_count >= 32'(MIN_GAPPED)) &&
                                 (r_sshape[LW-1:0] != '0) && (r_dshape[LW-1:0] != '0))
                              : (r_count >= 32'(MIN_FLAT));
    assign start_req = reg_we && (reg_addr == REG_CTRL) && reg_wdata[0] && !busy;
    assign launch    = start_req && legal;
    assign rd_valid  = busy && (rd_left != '0) && (occ < OCC_W'(FIFO_DEPTH));
    assign wr_valid  = !fifo_empty;
    assign rd_fire   = rd_valid && rd_ready;
    assign wr_fire   = wr_valid && wr_ready;

    // Configuration register writes, taken only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_src <= '0; r_dst <= '0; r_count <= '0;
            r_sshape <= '0; r_dshape <= '0; r_flags <= '0;
        end else if (reg_we && !busy) begin
            case (reg_addr)
                REG_SRC_BASE:  r_src    <= reg_wdata;
                REG_DST_BASE:  r_dst    <= reg_wdata;
                REG_COUNT:     r_count  <= reg_wdata;
                REG_SRC_SHAPE: r_sshape <= reg_wdata;
                REG_DST_SHAPE: r_dshape <= reg_wdata;
                REG_FLAGS:     r_flags  <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Register read mux.
    always_comb begin
        case (reg_addr)
            REG_SRC_BASE:  reg_rdata = r_src;
            REG_DST_BASE:  reg_rdata = r_dst;
            REG_COUNT:     reg_rdata = r_count;
            REG_SRC_SHAPE: reg_rdata = r_sshape;
            REG_DST_SHAPE: reg_rdata = r_dshape;
            REG_FLAGS:     reg_rdata = r_flags;
            REG_CTRL:      reg_rdata = {22'b0, err, done, 7'b0, busy};
            default:       reg_rdata = '0;
        endcase
    end

    // Launch, refusal and completion control with the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; done <= 1'b0; err <= 1'b0; irq <= 1'b0;
            wr_left <= '0;
        end else begin
            irq <= 1'b0;
            if (start_req) begin
                if (legal) begin
                    busy <= 1'b1; done <= 1'b0; err <= 1'b0;
                    wr_left <= beats;
                end else begin
                    done <= 1'b1; err <= 1'b1; irq <= 1'b1;
                end
            end else if (busy && wr_fire) begin
                wr_left <= wr_left - 32'd1;
                if (wr_left == 32'd1) begin
                    busy <= 1'b0; done <= 1'b1; irq <= 1'b1;
                end
            end
        end
    end

    // Remaining read beats to request.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_left <= '0;
        else if (launch)  rd_left <= beats;
        else if (rd_fire) rd_left <= rd_left - 32'd1;
    end

    // Credit: reads issued but not yet written out, bounded by FIFO depth.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else        occ <= occ + OCC_W'(rd_fire) - OCC_W'(wr_fire);
    end

    scopy_agen #(.AW(AW), .LW(LW)) u_src_agen (
        .clk(clk), .rst_n(rst_n), .load(launch),
        .base(AW'({r_src, 3'b000})), .width(r_sshape[15:0]), .gap(r_sshape[31:16]),
        .gapped(gapped), .step(rd_fire), .addr(rd_addr)
    );

    scopy_agen #(.AW(AW), .LW(LW)) u_dst_agen (
        .clk(clk), .rst_n(rst_n), .load(launch),
        .base(AW'({r_dst, 3'b000})), .width(r_dshape[15:0]), .gap(r_dshape[31:16]),
        .gapped(gapped), .step(wr_fire), .addr(wr_addr)
    );

    scopy_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(rd_rvalid), .din(rd_rdata),
        .pop(wr_fire), .dout(wr_data), .empty(fifo_empty)
    );
endmodule

// File: rtl/scopy_engine_chk.sv
// Module: protocol and control checker bound into the copy engine.
// Assumes in-order, one-per-request read responses from memory.
module scopy_engine_chk #(
    parameter int AW    = 32,
    parameter int DW    = 128,
    parameter int DEPTH = 4,
    parameter int OW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic [AW-1:0] rd_addr,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          irq,
    input logic          busy,
    input logic [OW-1:0] occ
);
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

    p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OW'(DEPTH));

    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_done_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_valid && !wr_valid);
endmodule

bind scopy_engine scopy_engine_chk #(.AW(AW), .DW(DW), .DEPTH(FIFO_DEPTH), .OW(OCC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq(irq), .busy(busy), .occ(occ)
);

// File: tb/tb_scopy_engine.sv
// Bench: behavioural memory responder plus a per-beat address and data model,
// compared on every clock of each transfer.
module tb_scopy_engine;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         reg_we;
    logic [2:0]   reg_addr;
    logic [31:0]  reg_wdata, reg_rdata;
    logic         rd_valid, rd_ready, rd_rvalid;
    logic [31:0]  rd_addr, wr_addr;
    logic [127:0] rd_rdata, wr_data;
    logic         wr_valid, wr_ready, irq;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int unsigned pend[$];

    always #2.5 clk = ~clk;

    scopy_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq(irq)
    );

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog act=%0d exp<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        vectors = vectors + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] mkdata(input logic [31:0] a);
        return {a ^ 32'hA5A5_0000, ~a, a * 32'd3, a + 32'h1234};
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] base, input int unsigned w,
                                             input int unsigned g, input bit gp, input int unsigned k);
        logic [31:0] b = base << 3;
        if (!gp) return b + 32'(16 * k);
        return b + 32'((k / w) * (w + g) * 16 + (k % w) * 16);
    endfunction

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // One transfer: program, start, then compare every cycle until irq.
    task automatic run(input string tag, input logic [31:0] src, input logic [31:0] dst,
                       input logic [31:0] cnt, input logic [31:0] ssh, input logic [31:0] dsh,
                       input logic [31:0] flg, input bit exp_err, input bit poke);
        int unsigned beats = (cnt + 15) / 16;
        bit gp = flg[2];
        int unsigned rk = 0, wk = 0, irqs = 0;
        bit seen = 0;
        logic [31:0] v, ea;
        wr_reg(3'd0, src); wr_reg(3'd1, dst); wr_reg(3'd2, cnt);
        wr_reg(3'd3, ssh); wr_reg(3'd4, dsh); wr_reg(3'd5, flg);
        wr_reg(3'd6, 32'h1);
        for (int c = 0; c < 4000 && !seen; c++) begin
            @(negedge clk);
            reg_we = (poke && c == 3);
            reg_addr = 3'd6; reg_wdata = 32'h1;
            rd_ready = ($urandom % 4) != 0;
            wr_ready = ($urandom % 4) != 0;
            if (pend.size() > 0 && ($urandom % 3) != 0) begin
                rd_rvalid = 1'b1; rd_rdata = mkdata(pend.pop_front());
            end else begin
                rd_rvalid = 1'b0;
            end
            #1;
            if (rd_valid && rd_ready) begin
                ea = exp_addr(src, ssh[15:0], ssh[31:16], gp, rk);
                chk(!exp_err && rk < beats, {tag, " R5/R7 extra read"}, rk, beats);
                chk(rd_addr == ea, {tag, gp ? " R4 read addr" : " R3 read addr"}, rd_addr, ea);
                pend.push_back(rd_addr);
                rk++;
            end
            if (wr_valid && wr_ready) begin
                ea = exp_addr(dst, dsh[15:0], dsh[31:16], gp, wk);
                chk(!exp_err && wk < beats, {tag, " R5/R7 extra write"}, wk, beats);
                chk(wr_addr == ea, {tag, gp ? " R4 write addr" : " R3 write addr"}, wr_addr, ea);
                chk(wr_data == mkdata(exp_addr(src, ssh[15:0], ssh[31:16], gp, wk)),
                    {tag, " R6 data"}, wr_data, mkdata(exp_addr(src, ssh[15:0], ssh[31:16], gp, wk)));
                wk++;
            end
            if (irq) begin
                seen = 1;
                irqs++;
            end
        end
        reg_we = 1'b0; rd_ready = 1'b0; wr_ready = 1'b0; rd_rvalid = 1'b0;
        chk(seen, {tag, " R8 irq seen"}, seen, 1);
        chk(rk == (exp_err ? 0 : beats), {tag, exp_err ? " R7 reads" : " R5 reads"}, rk, exp_err ? 0 : beats);
        chk(wk == (exp_err ? 0 : beats), {tag, exp_err ? " R7 writes" : " R5 writes"}, wk, exp_err ? 0 : beats);
        // Idle afterwards: single irq, no traffic.
        for (int c = 0; c < 6; c++) begin
            @(negedge clk); #1;
            if (irq || rd_valid || wr_valid) irqs++;
        end
        chk(irqs == 1, {tag, " R8/R9 single pulse quiet after"}, irqs, 1);
        rd_reg(3'd6, v);
        chk(v == {22'b0, exp_err, 1'b1, 8'b0}, {tag, " R2 ctrl status"}, v, {22'b0, exp_err, 1'b1, 8'b0});
        chk(pend.size() == 0, {tag, " R6 all responses used"}, pend.size(), 0);
    endtask

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        rd_ready = 1'b0; wr_ready = 1'b0; rd_rvalid = 1'b0; rd_rdata = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < 7; i++) begin
            rd_reg(3'(i), v);
            chk(v == 32'h0, "R11 reset reg", v, 0);
        end
        chk(!rd_valid && !wr_valid && !irq, "R11 reset outputs", {rd_valid, wr_valid, irq}, 0);
        // R1 readback of every config register
        wr_reg(3'd0, 32'h1234_5678); wr_reg(3'd3, 32'hDEAD_BEEF); wr_reg(3'd5, 32'hF0F0_0F0F);
        rd_reg(3'd0, v); chk(v == 32'h1234_5678, "R1 readback src", v, 32'h1234_5678);
        rd_reg(3'd3, v); chk(v == 32'hDEAD_BEEF, "R1 readback shape", v, 32'hDEAD_BEEF);
        rd_reg(3'd5, v); chk(v == 32'hF0F0_0F0F, "R1 readback flags", v, 32'hF0F0_0F0F);

        run("R3 flat64",      32'h0200, 32'h0800, 64,  32'h0002_0003, 32'h0005_0002, 32'h0, 0, 0);
        run("R5 flat40",      32'h0201, 32'h0903, 40,  32'h0, 32'h0, 32'h0, 0, 0);
        run("R4 gapped",      32'h0400, 32'h1000, 200, 32'h0002_0003, 32'h0005_0002, 32'h4, 0, 0);
        run("R3 bit2 clear",  32'h0400, 32'h1000, 200, 32'h0002_0003, 32'h0005_0002, 32'hFFFF_FFFB, 0, 0);
        run("R4 gap zero",    32'h0600, 32'h1400, 192, 32'h0000_0004, 32'h0000_0004, 32'h4, 0, 0);
        run("R7 min flat",    32'h0300, 32'h0700, 16,  32'h0, 32'h0, 32'h0, 0, 0);
        run("R7 small flat",  32'h0300, 32'h0700, 15,  32'h0, 32'h0, 32'h0, 1, 0);
        run("R7 small gap",   32'h0300, 32'h0700, 176, 32'h0001_0002, 32'h0001_0002, 32'h4, 1, 0);
        run("R7 src width0",  32'h0300, 32'h0700, 256, 32'h0001_0000, 32'h0001_0002, 32'h4, 1, 0);
        run("R7 dst width0",  32'h0300, 32'h0700, 256, 32'h0001_0002, 32'h0003_0000, 32'h4, 1, 0);
        run("R9 restart",     32'h0100, 32'h0A00, 256, 32'h0, 32'h0, 32'h0, 0, 1);
        run("R10 long gapped",32'h0800, 32'h2000, 600, 32'h0003_0005, 32'h0001_0007, 32'h4, 0, 0);

        summary();
        $finish;
    end
endmodule